// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block is a single-issue integer unit that performs clamped arithmetic on two DW-bit operands. The default is 32 bits. It offers signed and unsigned add and subtract that clamp instead of wrapping, and a signed doubling that clamps. It can also limit a signed value to a programmable bit width, producing either a signed or an unsigned result. That width limit also comes in a form with two independent half-width lanes.

Each operation is launched with a one-cycle start strobe. The result and a valid pulse appear one clock later. Whenever an operation clamps its result, a sticky saturation flag is raised. The flag stays high until the flag-clear input is asserted. Operations never lower the flag.

Top module: `sat_alu`

## Requirements
- R1: Operation code 0 is a signed add. When both operands have the same sign and the sum's sign differs from operand A, the result clamps to 0x7FFFFFFF if A is non-negative, or to 0x80000000 if A is negative.
- R2: Operation code 1 is a signed subtract (A minus B). When the operands differ in sign and the difference's sign differs from A, the result clamps to 0x7FFFFFFF or 0x80000000 according to the sign of A.
- R3: Operation code 2 is an unsigned add, which returns all ones when the sum would exceed 0xFFFFFFFF. Operation code 3 is an unsigned subtract, which returns zero when B is greater than A.
- R4: Operation code 4 doubles A as a signed value. Inputs at or above 0x40000000 give 0x7FFFFFFF. Inputs at or below 0xC0000000 (signed), including 0xC0000000 itself, give 0x80000000 and count as a clamp. All other inputs give A shifted left by one.
- R5: Operation code 5 limits signed A to the range -2^n to 2^n-1, where n is the 5-bit width field. Values above the range give 2^n-1. Values below the range give the complement of 2^n-1.
- R6: Operation code 6 limits signed A to the range 0 to 2^n-1. Negative values give 0. Values above 2^n-1 give 2^n-1.
- R7: Operation codes 7 (signed) and 8 (unsigned) apply the width limit of R5 and R6 separately to the sign-extended bits 15:0 and bits 31:16 of A. Each lane's result is truncated to 16 bits and placed back in its own lane.
- R8: Every clamp sets the sticky flag on the same edge that the result is registered. An operation that does not clamp leaves the flag as it was.
- R9: When flag clear is asserted, the flag is low after that edge, even if a clamping operation completes on the same edge.
- R10: Operation codes 9 to 15 return operand A unchanged and never set the flag.
- R11: The result and the valid output update one clock after a start. Valid is high for exactly one cycle per start. Without a start, the result register holds its value.
- R12: After reset, the result, valid and the flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 4 | Operation code |
| opa | input | DW | Operand A |
| opb | input | DW | Operand B |
| sat_width | input | $clog2(DW) | Width n for the width-limit operations |
| flag_clr | input | 1 | Clear the sticky flag |
| result | output | DW | Registered result |
| result_vld | output | 1 | One-cycle pulse when the result is new |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The result, the valid pulse and the flag change all take effect on the first rising edge after a start. So each is due one cycle after its stimulus. The bench drives inputs on the falling edge and updates its reference model at the moment it drives. It then compares all three outputs on the next falling edge, which is half a cycle after the edge that registers them. The comparison is made every cycle, including idle cycles, so the held result, a missing valid and any stray flag change are caught in the cycle where they occur.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
   typedef enum logic [3:0] {
      OP_SADD   = 4'd0,
      OP_SSUB   = 4'd1,
      OP_UADD   = 4'd2,
      OP_USUB   = 4'd3,
      OP_SDBL   = 4'd4,
      OP_SLIM   = 4'd5,
      OP_ULIM   = 4'd6,
      OP_SLIM2  = 4'd7,
      OP_ULIM2  = 4'd8
   } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   input  logic          uns,
   output logic [DW-1:0] res,
   output logic          clamp
);
   localparam int MSB = DW - 1;
   localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   logic [DW:0]   wide;
   logic [DW-1:0] raw;
   logic          cout;
   logic          sovf;

   always_comb begin
      wide = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{DW{1'b0}}, sub};
      raw  = wide[DW-1:0];
      cout = wide[DW];
      if (sub) sovf = (a[MSB] != b[MSB]) && (raw[MSB] != a[MSB]);
      else     sovf = (a[MSB] == b[MSB]) && (raw[MSB] != a[MSB]);
      clamp = 1'b0;
      res   = raw;
      if (uns) begin
         if (!sub && cout) begin
            clamp = 1'b1;
            res   = '1;
         end else if (sub && !cout) begin
            clamp = 1'b1;
            res   = '0;
         end
      end else if (sovf) begin
         clamp = 1'b1;
         res   = a[MSB] ? SMIN : SMAX;
      end
   end
endmodule

// File: rtl/sat_width.sv
module sat_width #(
   parameter int DW  = 32,
   parameter int SHW = $clog2(DW)
) (
   input  logic [DW-1:0]  val,
   input  logic [SHW-1:0] n,
   input  logic           uns,
   output logic [DW-1:0]  res,
   output logic           clamp
);
   localparam int MSB = DW - 1;
   localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

   logic [DW-1:0]        mask;
   logic signed [DW-1:0] top;
   logic                 above;
   logic                 below;

   always_comb begin
      mask = (ONE << n) - ONE;
      top  = $signed(val) >>> n;
      if (uns) begin
         below = val[MSB];
         above = !val[MSB] && (val > mask);
      end else begin
         above = !top[MSB] && (top != '0);
         below = top[MSB] && (top != '1);
      end
      clamp = above | below;
      if (above)      res = mask;
      else if (below) res = uns ? '0 : ~mask;
      else            res = val;
   end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (clr) flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end

   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
   a_r8_set_on_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !clr) |=> flag);
   a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/sat_alu.sv
module sat_alu
   import sat_alu_pkg::*;
#(
   parameter int DW  = 32,
   parameter int SHW = $clog2(DW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [3:0]     op,
   input  logic [DW-1:0]  opa,
   input  logic [DW-1:0]  opb,
   input  logic [SHW-1:0] sat_width,
   input  logic           flag_clr,
   output logic [DW-1:0]  result,
   output logic           result_vld,
   output logic           sat_flag
);
   localparam int MSB   = DW - 1;
   localparam int HW    = DW / 2;
   localparam int LANES = 2;
   localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   generate
      if (DW < 8 || (DW % 2) != 0) begin : g_bad_width
         $error("sat_alu: DW must be even and at least 8");
      end
      if (SHW != $clog2(DW)) begin : g_bad_shw
         $error("sat_alu: SHW must equal clog2(DW)");
      end
   endgenerate

   // add / subtract path
   logic          as_sub, as_uns;
   logic [DW-1:0] as_res;
   logic          as_clamp;

   assign as_sub = (op == OP_SSUB) || (op == OP_USUB);
   assign as_uns = (op == OP_UADD) || (op == OP_USUB);

   sat_addsub #(.DW(DW)) i_addsub (
      .a(opa), .b(opb), .sub(as_sub), .uns(as_uns),
      .res(as_res), .clamp(as_clamp)
   );

   // width limit lanes
   logic          dual, w_uns;
   logic [DW-1:0] lane_in  [LANES];
   logic [DW-1:0] lane_out [LANES];
   logic          lane_clamp [LANES];

   assign dual  = (op == OP_SLIM2) || (op == OP_ULIM2);
   assign w_uns = (op == OP_ULIM) || (op == OP_ULIM2);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         if (g == 0) begin : g_low
            assign lane_in[g] = dual ? {{HW{opa[HW-1]}}, opa[HW-1:0]} : opa;
         end else begin : g_high
            assign lane_in[g] = {{HW{opa[MSB]}}, opa[MSB:HW]};
         end
         sat_width #(.DW(DW), .SHW(SHW)) i_width (
            .val(lane_in[g]), .n(sat_width), .uns(w_uns),
            .res(lane_out[g]), .clamp(lane_clamp[g])
         );
      end
   endgenerate

   // doubling
   logic          dbl_hi, dbl_lo;
   logic [DW-1:0] dbl_res;

   always_comb begin
      dbl_hi = !opa[MSB] && opa[MSB-1];
      dbl_lo = opa[MSB] && (!opa[MSB-1] || (opa[MSB-2:0] == '0));
      if (dbl_hi)      dbl_res = SMAX;
      else if (dbl_lo) dbl_res = SMIN;
      else             dbl_res = {opa[MSB-1:0], 1'b0};
   end

   // select
   logic [DW-1:0] nxt_res;
   logic          nxt_clamp;

   always_comb begin
      nxt_res   = opa;
      nxt_clamp = 1'b0;
      case (op)
         OP_SADD, OP_SSUB, OP_UADD, OP_USUB: begin
            nxt_res   = as_res;
            nxt_clamp = as_clamp;
         end
         OP_SDBL: begin
            nxt_res   = dbl_res;
            nxt_clamp = dbl_hi | dbl_lo;
         end
         OP_SLIM, OP_ULIM: begin
            nxt_res   = lane_out[0];
            nxt_clamp = lane_clamp[0];
         end
         OP_SLIM2, OP_ULIM2: begin
            nxt_res   = {lane_out[1][HW-1:0], lane_out[0][HW-1:0]};
            nxt_clamp = lane_clamp[0] | lane_clamp[1];
         end
         default: begin
            nxt_res   = opa;
            nxt_clamp = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result     <= '0;
         result_vld <= 1'b0;
      end else begin
         result_vld <= start;
         if (start) result <= nxt_res;
      end
   end

   sat_sticky i_sticky (
      .clk(clk), .rst_n(rst_n), .set(start && nxt_clamp),
      .clr(flag_clr), .flag(sat_flag)
   );

   a_r11_vld_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> result_vld);
   a_r11_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !result_vld);
   a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(result));
   a_r10_unused_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op > 4'd8) |=> (result == $past(opa)));
   a_r10_unused_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op > 4'd8 && !flag_clr) |=> $stable(sat_flag));
endmodule

// File: tb/test_sat_alu.sv
`timescale 1ns/1ps
module test_sat_alu;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [3:0]  op;
   logic [31:0] opa, opb;
   logic [4:0]  sat_width;
   logic        flag_clr;
   logic [31:0] result;
   logic        result_vld;
   logic        sat_flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] e_res;
   logic        e_vld;
   logic        e_flag;
   string       e_rtag;
   string       e_ftag;

   always #2 clk = ~clk;

   sat_alu i_sat_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .sat_width(sat_width), .flag_clr(flag_clr), .result(result),
      .result_vld(result_vld), .sat_flag(sat_flag)
   );

   function automatic string op_tag(input logic [3:0] c);
      case (c)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2, 4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7, 4'd8: return "R7";
         default: return "R10";
      endcase
   endfunction

   function automatic longint lim_s(input longint v, input int n, inout bit s);
      longint hi = (longint'(1) <<< n) - 1;
      longint lo = -(longint'(1) <<< n);
      if (v > hi) begin s = 1; return hi; end
      if (v < lo) begin s = 1; return lo; end
      return v;
   endfunction

   function automatic longint lim_u(input longint v, input int n, inout bit s);
      longint hi = (longint'(1) <<< n) - 1;
      if (v < 0)  begin s = 1; return 0; end
      if (v > hi) begin s = 1; return hi; end
      return v;
   endfunction

   task automatic ref_op(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                         input int n, output logic [31:0] r, output bit s);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint ua = longint'({32'h0, a});
      longint ub = longint'({32'h0, b});
      longint t, t0, t1;
      s = 0;
      case (c)
         4'd0, 4'd1: begin
            t = (c == 4'd0) ? sa + sb : sa - sb;
            if (t > 64'sh7FFFFFFF)       begin s = 1; t = 64'sh7FFFFFFF; end
            else if (t < -64'sh80000000) begin s = 1; t = -64'sh80000000; end
            r = t[31:0];
         end
         4'd2: begin
            t = ua + ub;
            if (t > 64'shFFFFFFFF) begin s = 1; t = 64'shFFFFFFFF; end
            r = t[31:0];
         end
         4'd3: begin
            if (ub > ua) begin s = 1; r = 32'h0; end
            else r = 32'(ua - ub);
         end
         4'd4: begin
            if (sa >= 64'sh40000000)       begin s = 1; r = 32'h7FFFFFFF; end
            else if (sa <= -64'sh40000000) begin s = 1; r = 32'h80000000; end
            else begin t = sa * 2; r = t[31:0]; end
         end
         4'd5: begin t = lim_s(sa, n, s); r = t[31:0]; end
         4'd6: begin t = lim_u(sa, n, s); r = t[31:0]; end
         4'd7, 4'd8: begin
            t0 = longint'($signed(a[15:0]));
            t1 = longint'($signed(a[31:16]));
            if (c == 4'd7) begin t0 = lim_s(t0, n, s); t1 = lim_s(t1, n, s); end
            else           begin t0 = lim_u(t0, n, s); t1 = lim_u(t1, n, s); end
            r = {t1[15:0], t0[15:0]};
         end
         default: r = a;
      endcase
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(result === e_res, e_rtag, "result", result, e_res);
      chk(result_vld === e_vld, "R11", "valid", {31'h0, result_vld}, {31'h0, e_vld});
      chk(sat_flag === e_flag, e_ftag, "flag", {31'h0, sat_flag}, {31'h0, e_flag});
   endtask

   // drive on falling edge, model the next registered state, compare next falling edge
   task automatic step(input bit st, input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] n, input bit clr);
      logic [31:0] r;
      bit s;
      start = st; op = c; opa = a; opb = b; sat_width = n; flag_clr = clr;
      ref_op(c, a, b, int'(n), r, s);
      if (st) begin
         e_res = r; e_vld = 1'b1; e_rtag = op_tag(c);
      end else begin
         e_vld = 1'b0; e_rtag = "R11";
      end
      if (clr) begin e_flag = 1'b0; e_ftag = "R9"; end
      else begin
         if (st && s) e_flag = 1'b1;
         e_ftag = "R8";
      end
      @(negedge clk);
      compare();
   endtask

   task automatic run(input logic [3:0] c, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] n);
      step(1'b1, c, a, b, n, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; op = '0; opa = '0; opb = '0;
      sat_width = '0; flag_clr = 1'b0;
      e_res = '0; e_vld = 1'b0; e_flag = 1'b0; e_rtag = "R12"; e_ftag = "R12";
      repeat (3) @(negedge clk);
      compare();                    // R12 reset state
      rst_n = 1'b1;
      @(negedge clk);
      compare();

      // R1 signed add
      run(4'd0, 32'h00000005, 32'h00000007, 5'd0);
      run(4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0);
      run(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0);
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);   // R9 clear, R11 hold
      run(4'd0, 32'h80000000, 32'h7FFFFFFF, 5'd0);
      // R2 signed subtract
      run(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0);
      run(4'd1, 32'h80000000, 32'h00000001, 5'd0);
      run(4'd1, 32'h00000010, 32'h00000020, 5'd0);
      // R3 unsigned
      run(4'd2, 32'hFFFFFFF0, 32'h00000010, 5'd0);
      run(4'd2, 32'hFFFFFFF0, 32'h0000000F, 5'd0);
      run(4'd3, 32'h00000005, 32'h00000006, 5'd0);
      run(4'd3, 32'h00000006, 32'h00000006, 5'd0);
      // R4 doubling boundaries
      run(4'd4, 32'h3FFFFFFF, 32'h0, 5'd0);
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
      run(4'd4, 32'hC0000001, 32'h0, 5'd0);
      run(4'd4, 32'hC0000000, 32'h0, 5'd0);          // R4 counts as clamp
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
      run(4'd4, 32'h40000000, 32'h0, 5'd0);
      run(4'd4, 32'hBFFFFFFF, 32'h0, 5'd0);
      // R9 clear wins over simultaneous clamp
      step(1'b1, 4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b1);
      // R5 / R6 width limits
      run(4'd5, 32'h00000100, 32'h0, 5'd7);
      run(4'd5, 32'hFFFFFF00, 32'h0, 5'd7);
      run(4'd5, 32'hFFFFFF80, 32'h0, 5'd7);
      run(4'd5, 32'h12345678, 32'h0, 5'd0);
      run(4'd5, 32'h80000000, 32'h0, 5'd31);
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
      run(4'd6, 32'h0000007F, 32'h0, 5'd7);
      run(4'd6, 32'h00000080, 32'h0, 5'd7);
      run(4'd6, 32'hFFFFFFFF, 32'h0, 5'd12);
      // R7 dual halfword lanes
      run(4'd7, 32'h7FFF8000, 32'h0, 5'd7);
      run(4'd7, 32'h0010FFF0, 32'h0, 5'd7);
      run(4'd8, 32'h8000007F, 32'h0, 5'd7);
      run(4'd8, 32'h00FF0001, 32'h0, 5'd20);
      // R10 unused codes
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
      for (int c = 9; c < 16; c++) run(4'(c), 32'hCAFE0000 + 32'(c), 32'hFFFFFFFF, 5'd3);
      // mixed random stream
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] ra, rb, rr;
         ra = $urandom; rb = $urandom; rr = $urandom;
         if (rr[3]) ra = {{2{ra[31]}}, ra[29:0]} ^ 32'(rr[8:4]);
         step(rr[0] | rr[1], rr[15:12], ra, rb, rr[20:16], (rr[27:23] == 5'd0));
      end
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL R11 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule